// File: doc/BRIEF.md
# TFT Raster Timing Generator

This block produces the raster timing for a 16-bit active-matrix LCD panel. It runs on the pixel clock and walks a pixel counter across each line and a line counter down each frame. The horizontal display and blanking lengths are programmed in units of eight pixel clocks. The vertical display and blanking lengths are programmed in lines. Every programmed field stores its length minus one.

From the two counters the block decodes a frame pulse, a line pulse, a shift enable and a data-ready flag. While the raster is inside the active window, a 16-bit pixel word from the fetch logic is split into red, green and blue fields and driven to the panel. Outside that window the colour pins are held at zero.

The timing fields may change at any time. They are captured only when one frame ends and the next begins, so a frame already being scanned keeps its geometry.

Top module: `tft_raster_gen`

## Requirements
- R1: A synchronous active-high reset sets the pixel counter to 0 and the line counter to 0 and captures the timing fields. The first cycle after reset is pixel 0 of display line 0, with data_rdy high.
- R2: The pixel counter advances by one on every clock and counts from 0 to HD+HB-1, then returns to 0. HD = (hact_cfg+1)*8 and HB = (hblk_cfg+1)*8.
- R3: The line counter holds steady within a line and advances by one when the pixel counter wraps. It counts from 0 to VD+VB-1, then returns to 0. VD = vact_cfg+1 and VB = vblk_cfg+1.
- R4: data_rdy is high exactly when the pixel counter is below HD and the line counter is below VD.
- R5: When data_rdy is high, red = pix_in[15:11], grn = pix_in[10:5] and blu = pix_in[4:0]. When data_rdy is low, all three are 0.
- R6: line_pulse is high for exactly one clock per line, when the pixel counter equals HD, which is the first clock of horizontal blanking.
- R7: frame_pulse is high for every clock of the line whose line counter equals VD, which is the first line of vertical blanking.
- R8: shift_en is high on every clock of the display lines (line counter below VD) and low on every clock of the vertical blanking lines.
- R9: Changes on the four timing inputs have no effect until the clock on which the last pixel of the last line of a frame wraps to pixel 0, line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hact_cfg | input | 7 | Horizontal display length in units of 8 pixels, minus one |
| hblk_cfg | input | 5 | Horizontal blanking length in units of 8 pixels, minus one |
| vact_cfg | input | 10 | Vertical display length in lines, minus one |
| vblk_cfg | input | 6 | Vertical blanking length in lines, minus one |
| pix_in | input | 16 | RGB 5-6-5 pixel word for the current position |
| frame_pulse | output | 1 | High over the first vertical blanking line |
| line_pulse | output | 1 | One-clock pulse at the start of horizontal blanking |
| shift_en | output | 1 | Pixel shift enable, high during display lines |
| data_rdy | output | 1 | High over active pixels |
| col_cnt | output | 11 | Current pixel position in the line |
| row_cnt | output | 11 | Current line in the frame |
| red | output | 5 | Red field to the panel |
| grn | output | 6 | Green field to the panel |
| blu | output | 5 | Blue field to the panel |

## Verification
A corrupt pixel or line counter shows up at col_cnt and row_cnt on the next clock. Within one line it also moves the edges of data_rdy and line_pulse, and within one frame it moves frame_pulse. A timing shadow captured at the wrong moment looks different: the current frame's line length or frame height changes mid-frame, and a reference that loads only at frame wrap sees the difference on the first affected pixel. Gating errors show directly as non-zero colour outside the window, or as colour that does not match pix_in inside it.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

    localparam int HACT_W     = 7;
    localparam int HBLK_W     = 5;
    localparam int VACT_W     = 10;
    localparam int VBLK_W     = 6;
    localparam int GRAN_LOG2  = 3;
    localparam int PIX_W      = 16;
    localparam int RED_W      = 5;
    localparam int GRN_W      = 6;
    localparam int BLU_W      = 5;

    localparam int HMAX  = ((1 << HACT_W) + (1 << HBLK_W)) << GRAN_LOG2;
    localparam int VMAX  = (1 << VACT_W) + (1 << VBLK_W);
    localparam int COL_W = $clog2(HMAX);
    localparam int ROW_W = $clog2(VMAX);

    typedef struct packed {
        logic [HACT_W-1:0] hact;
        logic [HBLK_W-1:0] hblk;
        logic [VACT_W-1:0] vact;
        logic [VBLK_W-1:0] vblk;
    } raster_cfg_t;

    typedef struct packed {
        logic [COL_W-1:0] hact_end;
        logic [COL_W-1:0] hline_last;
        logic [ROW_W-1:0] vact_end;
        logic [ROW_W-1:0] vframe_last;
    } raster_lim_t;

    typedef struct packed {
        logic [RED_W-1:0] r;
        logic [GRN_W-1:0] g;
        logic [BLU_W-1:0] b;
    } rgb565_t;

    function automatic raster_lim_t cfg_to_lim(input raster_cfg_t c);
        raster_lim_t l;
        int hd, hb, vd, vb;
        hd = (int'(c.hact) + 1) << GRAN_LOG2;
        hb = (int'(c.hblk) + 1) << GRAN_LOG2;
        vd = int'(c.vact) + 1;
        vb = int'(c.vblk) + 1;
        l.hact_end    = COL_W'(hd);
        l.hline_last  = COL_W'(hd + hb - 1);
        l.vact_end    = ROW_W'(vd);
        l.vframe_last = ROW_W'(vd + vb - 1);
        return l;
    endfunction

endpackage

// File: rtl/tft_cfg_shadow.sv
module tft_cfg_shadow
    import tft_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  raster_cfg_t cfg_in,
    output raster_lim_t lim
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            lim <= cfg_to_lim(cfg_in);
        end
    end
endmodule

// File: rtl/tft_axis_counter.sv
module tft_axis_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_last;

    assign at_last = (cnt == last);
    assign wrap    = step && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            if (at_last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tft_out_stage.sv
module tft_out_stage
    import tft_timing_pkg::*;
(
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  raster_lim_t      lim,
    input  logic [PIX_W-1:0] pix,
    output logic             frame_pulse,
    output logic             line_pulse,
    output logic             shift_en,
    output logic             data_rdy,
    output rgb565_t          rgb
);
    logic h_vis;
    logic v_vis;

    always_comb begin
        h_vis       = (col < lim.hact_end);
        v_vis       = (row < lim.vact_end);
        data_rdy    = h_vis && v_vis;
        shift_en    = v_vis;
        line_pulse  = (col == lim.hact_end);
        frame_pulse = (row == lim.vact_end);
        rgb         = data_rdy ? rgb565_t'(pix) : '0;
    end
endmodule

// File: rtl/tft_raster_gen.sv
module tft_raster_gen
    import tft_timing_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HACT_W-1:0]    hact_cfg,
    input  logic [HBLK_W-1:0]    hblk_cfg,
    input  logic [VACT_W-1:0]    vact_cfg,
    input  logic [VBLK_W-1:0]    vblk_cfg,
    input  logic [PIX_W-1:0]     pix_in,
    output logic                 frame_pulse,
    output logic                 line_pulse,
    output logic                 shift_en,
    output logic                 data_rdy,
    output logic [COL_W-1:0]     col_cnt,
    output logic [ROW_W-1:0]     row_cnt,
    output logic [RED_W-1:0]     red,
    output logic [GRN_W-1:0]     grn,
    output logic [BLU_W-1:0]     blu
);
    raster_cfg_t cfg_req;
    raster_lim_t lim;
    rgb565_t     rgb;
    logic        line_wrap;
    logic        frame_wrap;

    assign cfg_req = '{hact: hact_cfg, hblk: hblk_cfg, vact: vact_cfg, vblk: vblk_cfg};

    tft_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_wrap),
        .cfg_in (cfg_req),
        .lim    (lim)
    );

    tft_axis_counter #(.W(COL_W)) u_hcnt (
        .clk  (clk),
        .rst  (rst),
        .step (1'b1),
        .last (lim.hline_last),
        .cnt  (col_cnt),
        .wrap (line_wrap)
    );

    tft_axis_counter #(.W(ROW_W)) u_vcnt (
        .clk  (clk),
        .rst  (rst),
        .step (line_wrap),
        .last (lim.vframe_last),
        .cnt  (row_cnt),
        .wrap (frame_wrap)
    );

    tft_out_stage u_out (
        .col         (col_cnt),
        .row         (row_cnt),
        .lim         (lim),
        .pix         (pix_in),
        .frame_pulse (frame_pulse),
        .line_pulse  (line_pulse),
        .shift_en    (shift_en),
        .data_rdy    (data_rdy),
        .rgb         (rgb)
    );

    assign red = rgb.r;
    assign grn = rgb.g;
    assign blu = rgb.b;
endmodule

// File: rtl/tft_raster_chk.sv
module tft_raster_chk
    import tft_timing_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic             frame_pulse,
    input logic             line_pulse,
    input logic             shift_en,
    input logic             data_rdy,
    input logic [RED_W-1:0] red,
    input logic [GRN_W-1:0] grn,
    input logic [BLU_W-1:0] blu
);
    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (col != '0) |-> (col == COL_W'($past(col) + 1'b1))); // R2
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (col != '0) |-> $stable(row)); // R3
    AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_pulse |=> !line_pulse); // R6
    AST_LINE_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        line_pulse |-> !data_rdy); // R6
    AST_RGB_DARK: assert property (@(posedge clk) disable iff (rst)
        !data_rdy |-> ({red, grn, blu} == '0)); // R5
    AST_DRDY_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        data_rdy |-> shift_en); // R8
    AST_FRAME_WHOLE_LINE: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && col != '0) |-> $past(frame_pulse)); // R7
    AST_FRAME_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> !shift_en); // R7
endmodule

bind tft_raster_gen tft_raster_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .col         (col_cnt),
    .row         (row_cnt),
    .frame_pulse (frame_pulse),
    .line_pulse  (line_pulse),
    .shift_en    (shift_en),
    .data_rdy    (data_rdy),
    .red         (red),
    .grn         (grn),
    .blu         (blu)
);

// File: tb/tft_raster_gen_test.sv
module tft_raster_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  hact_cfg = 7'd1;
    logic [4:0]  hblk_cfg = 5'd0;
    logic [9:0]  vact_cfg = 10'd2;
    logic [5:0]  vblk_cfg = 6'd1;
    logic [15:0] pix_in = 16'h0;
    logic        frame_pulse, line_pulse, shift_en, data_rdy;
    logic [10:0] col_cnt, row_cnt;
    logic [4:0]  red;
    logic [5:0]  grn;
    logic [4:0]  blu;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // reference state
    int mc = 0, mr = 0;
    int m_hd = 0, m_ht = 1, m_vd = 0, m_vt = 1;
    bit m_valid = 0;

    tft_raster_gen uut (
        .clk(clk), .rst(rst), .hact_cfg(hact_cfg), .hblk_cfg(hblk_cfg),
        .vact_cfg(vact_cfg), .vblk_cfg(vblk_cfg), .pix_in(pix_in),
        .frame_pulse(frame_pulse), .line_pulse(line_pulse), .shift_en(shift_en),
        .data_rdy(data_rdy), .col_cnt(col_cnt), .row_cnt(row_cnt),
        .red(red), .grn(grn), .blu(blu)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic load_ref();
        m_hd = (int'(hact_cfg) + 1) * 8;
        m_ht = m_hd + (int'(hblk_cfg) + 1) * 8;
        m_vd = int'(vact_cfg) + 1;
        m_vt = m_vd + int'(vblk_cfg) + 1;
    endtask

    // reference model advances on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            load_ref();
            mc = 0;
            mr = 0;
            m_valid = 1;
        end else if (m_valid) begin
            if (mc == m_ht - 1) begin
                mc = 0;
                if (mr == m_vt - 1) begin
                    mr = 0;
                    load_ref(); // R9: fields captured only here
                end else begin
                    mr = mr + 1;
                end
            end else begin
                mc = mc + 1;
            end
        end
        #1 pix_in = 16'($urandom);
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst && m_valid && !done) begin
            automatic bit act = (mc < m_hd) && (mr < m_vd);
            chk("R2 col_cnt", int'(col_cnt), mc);
            chk("R3 row_cnt", int'(row_cnt), mr);
            chk("R4 data_rdy", int'(data_rdy), int'(act));
            chk("R5 red", int'(red), act ? int'(pix_in[15:11]) : 0);
            chk("R5 grn", int'(grn), act ? int'(pix_in[10:5]) : 0);
            chk("R5 blu", int'(blu), act ? int'(pix_in[4:0]) : 0);
            chk("R6 line_pulse", int'(line_pulse), int'(mc == m_hd));
            chk("R7 frame_pulse", int'(frame_pulse), int'(mr == m_vd));
            chk("R8 shift_en", int'(shift_en), int'(mr < m_vd));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_and_check();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.5;
        chk("R1 reset col", int'(col_cnt), 0);
        chk("R1 reset row", int'(row_cnt), 0);
        @(negedge clk);
        chk("R1 first col", int'(col_cnt), 1);
        chk("R1 first row", int'(row_cnt), 0);
        chk("R1 first data_rdy", int'(data_rdy), 1);
    endtask

    initial begin
        reset_and_check();
        run(300);
        // R9: change timing mid-frame; model keeps old geometry until wrap
        hact_cfg = 7'd0; hblk_cfg = 5'd1; vact_cfg = 10'd1; vblk_cfg = 6'd0;
        run(37);
        hact_cfg = 7'd2; hblk_cfg = 5'd2;
        run(400);
        // widest line, one display line
        hact_cfg = 7'd127; hblk_cfg = 5'd31; vact_cfg = 10'd0; vblk_cfg = 6'd0;
        run(6000);
        // 640x480-style geometry
        hact_cfg = 7'd79; hblk_cfg = 5'd19; vact_cfg = 10'd479; vblk_cfg = 6'd44;
        run(4000);
        reset_and_check();
        run(2500);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wait (cycles >= 190000);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule